// File: doc/BRIEF.md
# Quarter-Chip Multipath Searcher

This block runs during a packet's preamble. It finds the code phase of a 32-chip spreading sequence and the strongest multipath arrivals. The stream of complex baseband samples comes at four samples per chip. After a start pulse the block stores just enough samples to cover every code alignment. It then scores each of the 128 quarter-chip offsets against the code supplied on `pn_code`.

Each score is built from four 8-chip partial correlations. The I and Q parts of every partial are clipped to 9-bit signed range. The partial is then reduced to the energy |I|+|Q|, and the four segment energies are summed. Segments are combined without regard to phase, so a large carrier offset that rotates the signal between segments does not cancel the score.

A sorted three-entry list keeps the best offsets found so far. When all offsets are scored, the block raises `done`. It then reports the three offsets as finger timings, together with their energies.

Top module: `path_searcher`

## Requirements
- R1: A start pulse accepted while idle or finished clears `done` and the result list, on the next clock edge. After that the block stores the next 252 samples presented with `in_valid` high, in order. Cycles with `in_valid` low are skipped and their data is not stored.
- R2: Bit c of `pn_code` gives chip c. A bit of 0 means +1 and a bit of 1 means -1. Offset k correlates stored sample k+4c with chip c, for c from 0 to 31.
- R3: Chips 0-7, 8-15, 16-23 and 24-31 form four segments. For each segment the I and Q sums are each clipped to the range [-255, 255]. An offset's energy is the sum, over the four segments, of |I|+|Q| of the clipped sums. The largest possible energy is 2040.
- R4: Slot 0, slot 1 and slot 2 report the highest, second and third energies over all 128 offsets, each with the offset that produced it.
- R5: On equal energies the lower offset takes the higher slot. The three reported offsets are always distinct.
- R6: A start pulse that arrives while samples are being stored or offsets are being scored is ignored. The search in progress finishes with the result it would have had without that pulse.
- R7: `done` rises once all 128 offsets have been scored. It stays high, with outputs unchanged, until the next accepted start.
- R8: After reset, `done` is low and all offsets and energies read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new search (pulse) |
| in_valid | input | 1 | Sample on in_i/in_q is valid this cycle |
| in_i | input | 6 | In-phase sample, signed |
| in_q | input | 6 | Quadrature sample, signed |
| pn_code | input | 32 | Spreading code, bit c is chip c |
| done | output | 1 | Search complete, results valid |
| path0_off | output | 7 | Offset with highest energy |
| path1_off | output | 7 | Offset with second energy |
| path2_off | output | 7 | Offset with third energy |
| path0_energy | output | 12 | Highest energy |
| path1_energy | output | 12 | Second energy |
| path2_energy | output | 12 | Third energy |

## Verification
The bench feeds an all-zero input, which makes every offset score zero. It checks that slots fill with offsets 0, 1 and 2. A sorter that replaced entries on equal energy would report late offsets instead. It feeds full-scale negative samples with an all-plus code. This drives every partial sum to -256, so the energy must saturate at 2040. A design without the clip would wrap or report 2048.

Sparse pulse paths and rectangular multipath separate the ranking and the code-sign mapping. A swapped sign convention or a wrong sample stride moves the winning offsets. Gaps in `in_valid`, with junk data on the idle cycles, catch a capture that stores invalid samples. Start pulses during capture and during scoring catch a block that restarts while busy.

// File: rtl/psrch_pkg.sv
// Package: shared state encoding for the path searcher.
// Assumes nothing beyond IEEE 1800-2017.
package psrch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAPT  = 3'd1,
        ST_SCORE = 3'd2,
        ST_FLUSH = 3'd3,
        ST_DONE  = 3'd4
    } psrch_state_t;
endpackage

// File: rtl/psrch_sample_store.sv
// Sample store: a write-addressed register file holding one capture window of
// I/Q samples. Assumes the read address is in range whenever it is used.
module psrch_sample_store #(
    parameter int SAMP_W = 6,
    parameter int DEPTH  = 252,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic signed [SAMP_W-1:0] wi,
    input  logic signed [SAMP_W-1:0] wq,
    input  logic [ADDR_W-1:0]        raddr,
    output logic signed [SAMP_W-1:0] ri,
    output logic signed [SAMP_W-1:0] rq
);
    logic signed [SAMP_W-1:0] mem_i [DEPTH];
    logic signed [SAMP_W-1:0] mem_q [DEPTH];

    // Store one sample pair per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_i[waddr] <= wi;
            mem_q[waddr] <= wq;
        end
    end

    // Read the sample pair asynchronously for the correlator.
    always_comb begin
        ri = mem_i[raddr];
        rq = mem_q[raddr];
    end
endmodule

// File: rtl/psrch_seg_corr.sv
// Segment correlator: takes one despread chip per cycle. It builds I/Q partial
// sums over a segment, clips each to symmetric PART_W range, and adds |I|+|Q|
// to the offset's energy. It emits a score on the last chip of the code.
// Assumes chips of one offset arrive consecutively in ascending order.
module psrch_seg_corr #(
    parameter int SAMP_W   = 6,
    parameter int PART_W   = 9,
    parameter int ENERGY_W = 12,
    parameter int OFF_W    = 7,
    parameter int N_SEG    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     in_vld,
    input  logic                     neg,
    input  logic signed [SAMP_W-1:0] xi,
    input  logic signed [SAMP_W-1:0] xq,
    input  logic                     seg_last,
    input  logic                     code_last,
    input  logic [OFF_W-1:0]         off_in,
    output logic                     score_vld,
    output logic [ENERGY_W-1:0]      score,
    output logic [OFF_W-1:0]         score_off
);
    localparam int ACC_W = PART_W + 1;
    localparam logic signed [ACC_W-1:0] LIM = ACC_W'((2 ** (PART_W - 1)) - 1);
    localparam logic [ENERGY_W-1:0] E_MAX = ENERGY_W'(N_SEG * 2 * ((2 ** (PART_W - 1)) - 1));

    logic signed [ACC_W-1:0] acc_i, acc_q, ext_i, ext_q, sum_i, sum_q;
    logic [PART_W-1:0]       mag_i, mag_q;
    logic [PART_W:0]         seg_e;
    logic [ENERGY_W-1:0]     energy, e_next;

    function automatic logic [PART_W-1:0] clip_mag(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] nv;
        nv = -v;
        if (v > LIM || v < -LIM) return LIM[PART_W-1:0];
        else if (v < 0)          return nv[PART_W-1:0];
        else                     return v[PART_W-1:0];
    endfunction

    // Despread the chip, extend the partial sums and form the segment energy.
    always_comb begin
        ext_i = {{(ACC_W-SAMP_W){xi[SAMP_W-1]}}, xi};
        ext_q = {{(ACC_W-SAMP_W){xq[SAMP_W-1]}}, xq};
        sum_i = neg ? acc_i - ext_i : acc_i + ext_i;
        sum_q = neg ? acc_q - ext_q : acc_q + ext_q;
        mag_i = clip_mag(sum_i);
        mag_q = clip_mag(sum_q);
        seg_e = {1'b0, mag_i} + {1'b0, mag_q};
        e_next = energy + ENERGY_W'(seg_e);
    end

    // Accumulate partials and energy, and emit a score at the end of the code.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_i     <= '0;
            acc_q     <= '0;
            energy    <= '0;
            score_vld <= 1'b0;
            score     <= '0;
            score_off <= '0;
        end else begin
            score_vld <= 1'b0;
            if (in_vld) begin
                if (seg_last) begin
                    acc_i  <= '0;
                    acc_q  <= '0;
                    energy <= code_last ? '0 : e_next;
                    if (code_last) begin
                        score_vld <= 1'b1;
                        score     <= e_next;
                        score_off <= off_in;
                    end
                end else begin
                    acc_i <= sum_i;
                    acc_q <= sum_q;
                end
            end
        end
    end

    a_r3_energy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        score_vld |-> score <= E_MAX);
endmodule

// File: rtl/psrch_top3.sv
// Ranked list: keeps the N highest scores in descending order. A new score is
// inserted only when it is strictly greater than an entry or an entry is
// empty, so on equal energy the earlier offset keeps its slot.
// Assumes scores arrive in ascending offset order.
module psrch_top3 #(
    parameter int N        = 3,
    parameter int ENERGY_W = 12,
    parameter int OFF_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_vld,
    input  logic [ENERGY_W-1:0] in_e,
    input  logic [OFF_W-1:0]    in_off,
    output logic [ENERGY_W-1:0] e_o   [N],
    output logic [OFF_W-1:0]    off_o [N],
    output logic                full
);
    logic [N-1:0] vld_q, gt;

    // Mark every slot the new score would outrank.
    always_comb begin
        for (int i = 0; i < N; i++) gt[i] = !vld_q[i] || (in_e > e_o[i]);
        full = &vld_q;
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_head
            // Head slot takes the new score when it outranks the current head.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    e_o[i] <= '0; off_o[i] <= '0; vld_q[i] <= 1'b0;
                end else if (in_vld && gt[i]) begin
                    e_o[i] <= in_e; off_o[i] <= in_off; vld_q[i] <= 1'b1;
                end
            end
        end else begin : g_tail
            // Lower slot takes the new score or shifts down from the slot above.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    e_o[i] <= '0; off_o[i] <= '0; vld_q[i] <= 1'b0;
                end else if (in_vld && gt[i]) begin
                    if (gt[i-1]) begin
                        e_o[i] <= e_o[i-1]; off_o[i] <= off_o[i-1]; vld_q[i] <= vld_q[i-1];
                    end else begin
                        e_o[i] <= in_e; off_o[i] <= in_off; vld_q[i] <= 1'b1;
                    end
                end
            end

            a_r4_sorted: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[i] |-> (vld_q[i-1] && e_o[i-1] >= e_o[i]));
            a_r5_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[i] |-> off_o[i] != off_o[i-1]);
        end
    end
endmodule

// File: rtl/path_searcher.sv
// Path searcher top: captures one window of samples after a start pulse. It
// scores every quarter-chip offset with segmented noncoherent correlation and
// reports the three strongest offsets. Assumes pn_code is stable during search.
module path_searcher #(
    parameter int SAMP_W  = 6,
    parameter int PN_LEN  = 32,
    parameter int SEG_LEN = 8,
    parameter int SPS     = 4,
    parameter int PART_W  = SAMP_W + $clog2(SEG_LEN),
    parameter int OFF_W   = $clog2(SPS * PN_LEN),
    parameter int ENERGY_W = PART_W + 1 + $clog2(PN_LEN / SEG_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    input  logic [PN_LEN-1:0]        pn_code,
    output logic                     done,
    output logic [OFF_W-1:0]         path0_off,
    output logic [OFF_W-1:0]         path1_off,
    output logic [OFF_W-1:0]         path2_off,
    output logic [ENERGY_W-1:0]      path0_energy,
    output logic [ENERGY_W-1:0]      path1_energy,
    output logic [ENERGY_W-1:0]      path2_energy
);
    import psrch_pkg::*;

    localparam int N_OFF   = SPS * PN_LEN;
    localparam int N_SEG   = PN_LEN / SEG_LEN;
    localparam int CAP_LEN = N_OFF + SPS * (PN_LEN - 1);
    localparam int ADDR_W  = $clog2(CAP_LEN);
    localparam int CHIP_W  = $clog2(PN_LEN);
    localparam int N_PATHS = 3;

    psrch_state_t              st;
    logic [ADDR_W-1:0]         wr_ptr, raddr;
    logic [OFF_W-1:0]          off_q;
    logic [CHIP_W-1:0]         chip_q;
    logic                      start_ok, scoring, seg_last, code_last, full;
    logic signed [SAMP_W-1:0]  rd_i, rd_q;
    logic                      sc_vld;
    logic [ENERGY_W-1:0]       sc_e;
    logic [OFF_W-1:0]          sc_off;
    logic [ENERGY_W-1:0]       best_e   [N_PATHS];
    logic [OFF_W-1:0]          best_off [N_PATHS];

    // Decode control strobes and the sample address of the current chip.
    always_comb begin
        start_ok  = start && (st == ST_IDLE || st == ST_DONE);
        scoring   = (st == ST_SCORE);
        seg_last  = (int'(chip_q) % SEG_LEN) == SEG_LEN - 1;
        code_last = chip_q == CHIP_W'(PN_LEN - 1);
        raddr     = ADDR_W'(off_q) + ADDR_W'(chip_q) * ADDR_W'(SPS);
        done      = (st == ST_DONE);
    end

    // Sequence capture, scoring of every offset and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; wr_ptr <= '0; off_q <= '0; chip_q <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: if (start) begin
                    st <= ST_CAPT; wr_ptr <= '0;
                end
                ST_CAPT: if (in_valid) begin
                    wr_ptr <= wr_ptr + 1'b1;
                    if (wr_ptr == ADDR_W'(CAP_LEN - 1)) begin
                        st <= ST_SCORE; off_q <= '0; chip_q <= '0;
                    end
                end
                ST_SCORE: begin
                    chip_q <= chip_q + 1'b1;
                    if (code_last) begin
                        off_q <= off_q + 1'b1;
                        if (off_q == OFF_W'(N_OFF - 1)) st <= ST_FLUSH;
                    end
                end
                ST_FLUSH: st <= ST_DONE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    psrch_sample_store #(.SAMP_W(SAMP_W), .DEPTH(CAP_LEN), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(st == ST_CAPT && in_valid), .waddr(wr_ptr), .wi(in_i), .wq(in_q),
        .raddr(raddr), .ri(rd_i), .rq(rd_q)
    );

    psrch_seg_corr #(.SAMP_W(SAMP_W), .PART_W(PART_W), .ENERGY_W(ENERGY_W),
                     .OFF_W(OFF_W), .N_SEG(N_SEG)) u_corr (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .in_vld(scoring), .neg(pn_code[chip_q]),
        .xi(rd_i), .xq(rd_q), .seg_last(seg_last), .code_last(code_last), .off_in(off_q),
        .score_vld(sc_vld), .score(sc_e), .score_off(sc_off)
    );

    psrch_top3 #(.N(N_PATHS), .ENERGY_W(ENERGY_W), .OFF_W(OFF_W)) u_rank (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .in_vld(sc_vld), .in_e(sc_e),
        .in_off(sc_off), .e_o(best_e), .off_o(best_off), .full(full)
    );

    assign path0_off    = best_off[0];
    assign path1_off    = best_off[1];
    assign path2_off    = best_off[2];
    assign path0_energy = best_e[0];
    assign path1_energy = best_e[1];
    assign path2_energy = best_e[2];

    a_r1_skip_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPT && !in_valid) |=> $stable(wr_ptr));
    a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCORE && start) |=> st != ST_CAPT);
    a_r7_done_full: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> full);
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(path0_energy) && $stable(path2_off)));
endmodule

// File: tb/test_path_searcher.sv
// Scoreboard bench: the driver computes expected rankings from the
// requirements, and the monitor compares them when done rises.
module test_path_searcher;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [5:0] in_i = '0, in_q = '0;
    logic [31:0]       pn_code = 32'hB3A1_6C5D;
    logic              done;
    logic [6:0]        p0o, p1o, p2o;
    logic [11:0]       p0e, p1e, p2e;

    typedef struct { int e[3]; int o[3]; string tag; } exp_t;
    exp_t sbq[$];
    int si[252], sq[252];
    int n_chk = 0, n_bad = 0, n_seen = 0;

    path_searcher i_path_searcher (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_i(in_i),
        .in_q(in_q), .pn_code(pn_code), .done(done), .path0_off(p0o), .path1_off(p1o),
        .path2_off(p2o), .path0_energy(p0e), .path1_energy(p1e), .path2_energy(p2e)
    );

    always #10 clk = ~clk;

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int csign(int c);
        return pn_code[c] ? -1 : 1;
    endfunction

    function automatic int clipv(int v);
        return v > 255 ? 255 : (v < -255 ? -255 : v);
    endfunction

    function automatic int absv(int v);
        return v < 0 ? -v : v;
    endfunction

    // Path contribution at sample n: rectangular chips or one pulse per chip.
    function automatic int pathv(int n, int d, int amp, bit pulse);
        int k;
        if (n < d) return 0;
        k = n - d;
        if (pulse && (k % 4) != 0) return 0;
        return amp * csign((k / 4) % 32);
    endfunction

    function automatic int sat6(int v);
        return v > 31 ? 31 : (v < -32 ? -32 : v);
    endfunction

    // Model R2, R3, R4 and R5: score every offset and rank with strict insertion.
    function automatic void build_expected(string tag);
        exp_t x;
        bit   v[3];
        x.tag = tag;
        for (int s = 0; s < 3; s++) begin x.e[s] = 0; x.o[s] = 0; v[s] = 0; end
        for (int k = 0; k < 128; k++) begin
            int en = 0;
            int pos = 3;
            for (int g = 0; g < 4; g++) begin
                int pi = 0, pq = 0;
                for (int c = g * 8; c < g * 8 + 8; c++) begin
                    pi += csign(c) * si[k + 4 * c];
                    pq += csign(c) * sq[k + 4 * c];
                end
                en += absv(clipv(pi)) + absv(clipv(pq));
            end
            for (int s = 2; s >= 0; s--) if (!v[s] || en > x.e[s]) pos = s;
            if (pos < 3) begin
                for (int s = 2; s > pos; s--) begin
                    x.e[s] = x.e[s-1]; x.o[s] = x.o[s-1]; v[s] = v[s-1];
                end
                x.e[pos] = en; x.o[pos] = k; v[pos] = 1;
            end
        end
        sbq.push_back(x);
    endfunction

    // Driver: start a search and stream the window, optionally with gaps and busy starts.
    task automatic run_case(string tag, bit gaps, bit poke);
        int target;
        build_expected(tag);
        target = n_seen + 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R1 done cleared by start", int'(done), 0);
        for (int n = 0; n < 252; n++) begin
            if (gaps && (n % 3) == 0) begin
                in_valid = 1'b0; in_i = 6'sd31; in_q = -6'sd32;
                @(negedge clk);
            end
            in_valid = 1'b1; in_i = si[n][5:0]; in_q = sq[n][5:0];
            start = poke && (n == 100);
            @(negedge clk);
        end
        in_valid = 1'b0; start = 1'b0; in_i = 6'sd31; in_q = 6'sd31;
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        wait (n_seen == target);
        repeat (20) @(negedge clk);
        check({"R7 done held ", tag}, int'(done), 1);
    endtask

    // Monitor: on each rise of done, compare the ranked outputs with the queue head.
    initial begin
        forever begin
            exp_t x;
            @(posedge done);
            @(negedge clk);
            if (sbq.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R7 unexpected done: actual 1 expected 0");
            end else begin
                x = sbq.pop_front();
                check({"R4 slot0 energy ", x.tag}, int'(p0e), x.e[0]);
                check({"R4 slot1 energy ", x.tag}, int'(p1e), x.e[1]);
                check({"R4 slot2 energy ", x.tag}, int'(p2e), x.e[2]);
                check({"R5 slot0 offset ", x.tag}, int'(p0o), x.o[0]);
                check({"R5 slot1 offset ", x.tag}, int'(p1o), x.o[1]);
                check({"R5 slot2 offset ", x.tag}, int'(p2o), x.o[2]);
            end
            n_seen++;
        end
    end

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset done", int'(done), 0);
        check("R8 reset off0", int'(p0o), 0);
        check("R8 reset off1", int'(p1o), 0);
        check("R8 reset off2", int'(p2o), 0);
        check("R8 reset e0", int'(p0e), 0);
        check("R8 reset e1", int'(p1e), 0);
        check("R8 reset e2", int'(p2e), 0);

        // R2: single pulse path on I.
        for (int n = 0; n < 252; n++) begin si[n] = pathv(n, 37, 20, 1); sq[n] = 0; end
        run_case("R2 single pulse", 0, 0);

        // R4: three pulse paths, one also on Q.
        for (int n = 0; n < 252; n++) begin
            si[n] = sat6(pathv(n, 5, 10, 1) + pathv(n, 64, 14, 1) + pathv(n, 126, 6, 1));
            sq[n] = pathv(n, 64, 9, 1);
        end
        run_case("R4 three pulses", 0, 0);

        // R5: all-zero input ties every offset at zero.
        for (int n = 0; n < 252; n++) begin si[n] = 0; sq[n] = 0; end
        run_case("R5 all ties", 0, 0);

        // R3: full-scale negative samples with an all-plus code saturate each partial.
        pn_code = 32'h0;
        for (int n = 0; n < 252; n++) begin si[n] = -32; sq[n] = -32; end
        run_case("R3 clip", 0, 0);
        pn_code = 32'hB3A1_6C5D;

        // R1 and R6: rectangular multipath with input gaps and busy start pulses.
        for (int n = 0; n < 252; n++) begin
            si[n] = sat6(pathv(n, 20, 15, 0) + pathv(n, 22, -9, 0));
            sq[n] = sat6(pathv(n, 90, 11, 0));
        end
        run_case("R1 R6 gaps and busy start", 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule